// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with Prefix-Driven Result Negation

This block performs the integer multiply and divide operations of an accumulator-style 16-bit datapath. It handles unsigned and signed operations at 8-bit and 16-bit operand widths. A single start pulse launches an operation. The block turns signed operands into magnitudes and runs an unsigned loop that resolves one operand bit per clock. It then restores the signs and registers the new accumulator contents together with a one-cycle completion pulse.

The instruction decoder also supplies its repeat-prefix state. Any active repeat prefix turns into a "negate the result" control. That control is captured unchanged when the operation starts; nothing clears it. With the prefix present, a multiply writes back the two's complement of its product and a signed divide writes back a negated quotient.

The outputs always show the full new values of the low accumulator (the AX role) and the high accumulator (the DX role). The surrounding datapath writes them back when `done` is high.

Top module: `muldiv_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_lo`, `res_hi`, `done`, `div_err` and `wide_ovf` become 0, and `busy` is 0.
- R2: A `start` sampled while `busy` is low is accepted. `busy` rises after that edge. `done` is high for exactly one cycle, n+1 edges after the accepting edge, where n is 8 in byte mode and 16 otherwise. `busy` falls at the same edge. A `start` sampled while `busy` is high is ignored. `res_lo`, `res_hi` and `wide_ovf` change only when `done` rises.
- R3: `op`=2'b00 is an unsigned multiply. In byte mode (`byte_mode`=1), `res_lo` is the 16-bit product of `acc_lo[7:0]` and `src[7:0]` and `res_hi` equals `acc_hi`. In word mode, {`res_hi`,`res_lo`} is the 32-bit product of `acc_lo` and `src`. Without a prefix, 3 times 2 gives `res_lo`=6.
- R4: `op`=2'b01 is a signed multiply of the same operands, read as two's complement, with the same result layout as R3.
- R5: After a multiply, `wide_ovf` is 1 when the upper half of the true product carries information. For unsigned operations this means it is nonzero. For signed operations it means it is not the sign extension of the lower half. After a divide, `wide_ovf` is 0.
- R6: When the prefix is active, both multiplies return the two's complement of the true product over the full result width. For example, 3 times 2 in word mode gives `res_lo`=16'hFFFA and `res_hi`=16'hFFFF.
- R7: `rep_mode` encodes 2'b00 as no prefix, 2'b01 as the repeat-while-equal prefix and 2'b10 as the repeat-while-not-equal prefix. Every nonzero value gives the same result.
- R8: `op`=2'b10 is an unsigned divide. In byte mode the dividend is `acc_lo`, the divisor is `src[7:0]`, the quotient goes to `res_lo[7:0]`, the remainder goes to `res_lo[15:8]` and `res_hi` equals `acc_hi`. In word mode the dividend is {`acc_hi`,`acc_lo`}, the quotient goes to `res_lo` and the remainder goes to `res_hi`.
- R9: `op`=2'b11 is a signed divide with the layout of R8. The quotient rounds toward zero. It is negative when the operand signs differ, and the remainder carries the sign of the dividend.
- R10: With the prefix active, a signed divide returns the negated quotient and an unchanged remainder. An unsigned divide is not affected by the prefix.
- R11: A zero divisor, or a quotient outside the destination range, raises `div_err` together with `done` and leaves `res_lo`/`res_hi` equal to the `acc_lo`/`acc_hi` of that operation. The unsigned range is 0 to 2^n-1. The signed range is -2^(n-1) to 2^(n-1)-1, checked before any prefix negation.
- R12: The prefix is sampled only on the accepting edge and stays in force for the whole operation. Changes on `rep_mode` while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches an operation when the block is idle |
| op | input | 2 | 00 unsigned mul, 01 signed mul, 10 unsigned div, 11 signed div |
| byte_mode | input | 1 | 1 selects 8-bit operand width |
| rep_mode | input | 2 | Repeat-prefix state from the decoder; nonzero negates |
| acc_lo | input | W | Low accumulator operand |
| acc_hi | input | W | High accumulator operand |
| src | input | W | Source operand (multiplier or divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Divide error, valid with done |
| wide_ovf | output | 1 | Upper product half is significant |
| res_lo | output | W | New low accumulator value |
| res_hi | output | W | New high accumulator value |

## Verification
Two situations are hard to reach from the ports. The first is the asymmetric signed quotient limit: a quotient of -2^(n-1) must be accepted while +2^(n-1) must trap. The stimulus reaches it with dividends of exactly minus and plus twice the limit divided by 2, in byte mode, and then repeats the accepted case with the prefix so that negation wraps back onto itself. The second is a prefix that moves while the loop is running. The bench flips `rep_mode` and also pulses a stray `start` carrying different operands halfway through an operation. The model, which sampled everything on the accepting edge, then tells whether either change leaked into the result.

// File: rtl/muldiv_pkg.sv
// Shared types for the multiply/divide unit.
package muldiv_pkg;

    // Operation select; bit 1 = divide, bit 0 = signed.
    typedef enum logic [1:0] {
        OP_MULU = 2'b00,
        OP_MULS = 2'b01,
        OP_DIVU = 2'b10,
        OP_DIVS = 2'b11
    } md_op_e;

    // Control captured when an operation is accepted.
    typedef struct packed {
        logic neg_main;   // true product/quotient is negative
        logic neg_rem;    // remainder takes a negative sign
        logic is_div;     // divide rather than multiply
        logic is_signed;  // signed operation
        logic byte_w;     // 8-bit operand width
        logic negate;     // prefix-driven negation of the result
    } md_ctl_t;

endpackage

// File: rtl/muldiv_prep.sv
// Operand preparation: turns the selected operands into unsigned
// magnitudes and derives the sign of each result.
// Assumes W is even; byte mode uses the low W/2 bits of each operand,
// except the byte-mode dividend, which is the whole of acc_lo.
module muldiv_prep
    import muldiv_pkg::*;
#(
    parameter int W = 16
) (
    input  md_op_e          op,
    input  logic            byte_w,
    input  logic [W-1:0]    acc_lo,
    input  logic [W-1:0]    acc_hi,
    input  logic [W-1:0]    src,
    output logic [W-1:0]    mag_src,
    output logic [W-1:0]    mag_lo,
    output logic [W-1:0]    mag_hi,
    output logic            neg_main,
    output logic            neg_rem
);
    localparam int H = W / 2;

    logic           sgn;
    logic           is_div;
    logic           s_src, s_acc, s_dvd;
    logic [W-1:0]   src_ext, acc_ext, acc_mag;
    logic [2*W-1:0] dvd, dvd_mag;

    // Sign-extend (signed) or zero-extend (unsigned) narrow operands, then take magnitudes.
    always_comb begin
        sgn     = (op == OP_MULS) || (op == OP_DIVS);
        is_div  = (op == OP_DIVU) || (op == OP_DIVS);
        s_src   = sgn & (byte_w ? src[H-1] : src[W-1]);
        src_ext = byte_w ? {{H{src[H-1] & sgn}}, src[H-1:0]} : src;
        mag_src = s_src ? -src_ext : src_ext;
        s_acc   = sgn & (byte_w ? acc_lo[H-1] : acc_lo[W-1]);
        acc_ext = byte_w ? {{H{acc_lo[H-1] & sgn}}, acc_lo[H-1:0]} : acc_lo;
        acc_mag = s_acc ? -acc_ext : acc_ext;
        dvd     = byte_w ? {{W{acc_lo[W-1] & sgn}}, acc_lo} : {acc_hi, acc_lo};
        s_dvd   = sgn & dvd[2*W-1];
        dvd_mag = s_dvd ? -dvd : dvd;
    end

    // Route the magnitudes and signs for the selected operation class.
    always_comb begin
        if (is_div) begin
            mag_lo   = byte_w ? {{H{1'b0}}, dvd_mag[H-1:0]} : dvd_mag[W-1:0];
            mag_hi   = byte_w ? {{H{1'b0}}, dvd_mag[W-1:H]} : dvd_mag[2*W-1:W];
            neg_main = s_dvd ^ s_src;
            neg_rem  = s_dvd;
        end else begin
            mag_lo   = acc_mag;
            mag_hi   = '0;
            neg_main = s_acc ^ s_src;
            neg_rem  = 1'b0;
        end
    end

endmodule

// File: rtl/muldiv_core.sv
// Iterative unsigned engine: one operand bit per clock, MSB first.
// Multiply: shift-add into a 2W accumulator.
// Divide: restoring shift-subtract of the low dividend half into a
// remainder preloaded with the high half.
// Assumes is_div is held stable by the caller while running.
module muldiv_core #(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             is_div,
    input  logic             byte_w,
    input  logic [W-1:0]     op_src,
    input  logic [W-1:0]     op_lo,
    input  logic [W-1:0]     op_hi,
    output logic             running,
    output logic             fin,
    output logic             pre_ovf,
    output logic [2*W-1:0]   prod,
    output logic [W-1:0]     quo,
    output logic [W-1:0]     rem
);
    localparam int H  = W / 2;
    localparam int IW = $clog2(W);

    logic [IW-1:0] idx;
    logic [W-1:0]  src_q, lo_q;
    logic          bit_in;
    logic [W:0]    trial;

    // Current operand bit and the trial partial remainder.
    always_comb begin
        bit_in = lo_q[idx];
        trial  = {rem, bit_in};
    end

    // Load operands, then step one bit per cycle until the index reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            src_q   <= '0;
            lo_q    <= '0;
            rem     <= '0;
            quo     <= '0;
            prod    <= '0;
            pre_ovf <= 1'b0;
            running <= 1'b0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                src_q   <= op_src;
                lo_q    <= op_lo;
                rem     <= op_hi;
                quo     <= '0;
                prod    <= '0;
                pre_ovf <= (op_hi >= op_src);
                idx     <= byte_w ? IW'(H-1) : IW'(W-1);
                running <= 1'b1;
            end else if (running) begin
                if (is_div) begin
                    if (trial >= {1'b0, src_q}) begin
                        rem <= W'(trial - {1'b0, src_q});
                        quo <= {quo[W-2:0], 1'b1};
                    end else begin
                        rem <= trial[W-1:0];
                        quo <= {quo[W-2:0], 1'b0};
                    end
                end else begin
                    prod <= {prod[2*W-2:0], 1'b0}
                          + (bit_in ? {{W{1'b0}}, src_q} : {2*W{1'b0}});
                end
                if (idx == '0) begin
                    running <= 1'b0;
                    fin     <= 1'b1;
                end else begin
                    idx <= idx - 1'b1;
                end
            end
        end
    end

    // R2
    fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

    // R2
    last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !load && idx == '0) |=> (fin && !running));

    // R8
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && is_div && !pre_ovf) |-> (rem < src_q));

endmodule

// File: rtl/muldiv_fix.sv
// Result fix-up: applies signs and prefix negation, detects divide
// errors and the wide-product flag, and lays results out as new
// low/high accumulator values.
// Assumes its inputs are the registered engine outputs and captured control.
module muldiv_fix
    import muldiv_pkg::*;
#(
    parameter int W = 16
) (
    input  md_ctl_t          ctl,
    input  logic [2*W-1:0]   prod,
    input  logic [W-1:0]     quo,
    input  logic [W-1:0]     rem,
    input  logic             pre_ovf,
    input  logic [W-1:0]     lat_lo,
    input  logic [W-1:0]     lat_hi,
    output logic [W-1:0]     new_lo,
    output logic [W-1:0]     new_hi,
    output logic             err,
    output logic             ovf
);
    localparam int H = W / 2;

    logic [2*W-1:0] true_p, out_p;
    logic [W-1:0]   lim_base, q_lim, q_fin, r_fin;
    logic           ovf_u, ovf_s, q_bad;

    // Signed product and prefix-negated product; upper-half significance.
    always_comb begin
        true_p = ctl.neg_main ? -prod : prod;
        out_p  = (ctl.neg_main ^ ctl.negate) ? -prod : prod;
        ovf_u  = ctl.byte_w ? (|true_p[W-1:H]) : (|true_p[2*W-1:W]);
        ovf_s  = ctl.byte_w ? (true_p[W-1:H] != {H{true_p[H-1]}})
                            : (true_p[2*W-1:W] != {W{true_p[W-1]}});
    end

    // Signed quotient range, then signed/negated quotient and remainder.
    always_comb begin
        lim_base = ctl.byte_w ? (W'(1) << (H-1)) : (W'(1) << (W-1));
        q_lim    = lim_base - {{(W-1){1'b0}}, ~ctl.neg_main};
        q_bad    = ctl.is_signed & (quo > q_lim);
        err      = ctl.is_div & (pre_ovf | q_bad);
        q_fin    = (ctl.is_signed & (ctl.neg_main ^ ctl.negate)) ? -quo : quo;
        r_fin    = ctl.neg_rem ? -rem : rem;
    end

    // Lay out the new accumulator values for each operation class.
    always_comb begin
        if (!ctl.is_div) begin
            ovf    = ctl.is_signed ? ovf_s : ovf_u;
            new_lo = out_p[W-1:0];
            new_hi = ctl.byte_w ? lat_hi : out_p[2*W-1:W];
        end else begin
            ovf = 1'b0;
            if (err) begin
                new_lo = lat_lo;
                new_hi = lat_hi;
            end else if (ctl.byte_w) begin
                new_lo = {r_fin[H-1:0], q_fin[H-1:0]};
                new_hi = lat_hi;
            end else begin
                new_lo = q_fin;
                new_hi = r_fin;
            end
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
// Top of the multiply/divide unit. Accepts a start when idle and
// captures operands, width and the repeat-prefix negate control. It
// runs the iterative engine and registers the fixed-up accumulator
// values with a one-cycle done pulse.
// Assumes the caller writes res_lo/res_hi back only while done is high.
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic         byte_mode,
    input  logic [1:0]   rep_mode,
    input  logic [W-1:0] acc_lo,
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] src,
    output logic         busy,
    output logic         done,
    output logic         div_err,
    output logic         wide_ovf,
    output logic [W-1:0] res_lo,
    output logic [W-1:0] res_hi
);
    md_ctl_t        ctl_q;
    logic [W-1:0]   lat_lo, lat_hi;
    logic [W-1:0]   mag_src, mag_lo, mag_hi;
    logic           neg_main, neg_rem;
    logic           accept, running, fin, pre_ovf;
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo, rem;
    logic [W-1:0]   new_lo, new_hi;
    logic           err, ovf;

    // Busy spans the engine run plus its finishing cycle; accept only when idle.
    always_comb begin
        busy   = running | fin;
        accept = start & ~busy;
    end

    muldiv_prep #(.W(W)) u_prep (
        .op       (md_op_e'(op)),
        .byte_w   (byte_mode),
        .acc_lo   (acc_lo),
        .acc_hi   (acc_hi),
        .src      (src),
        .mag_src  (mag_src),
        .mag_lo   (mag_lo),
        .mag_hi   (mag_hi),
        .neg_main (neg_main),
        .neg_rem  (neg_rem)
    );

    // Capture control, including the prefix, and original accumulators on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            lat_lo <= '0;
            lat_hi <= '0;
        end else if (accept) begin
            ctl_q  <= '{neg_main:  neg_main,
                        neg_rem:   neg_rem,
                        is_div:    op[1],
                        is_signed: op[0],
                        byte_w:    byte_mode,
                        negate:    |rep_mode};
            lat_lo <= acc_lo;
            lat_hi <= acc_hi;
        end
    end

    muldiv_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .is_div  (ctl_q.is_div),
        .byte_w  (byte_mode),
        .op_src  (mag_src),
        .op_lo   (mag_lo),
        .op_hi   (mag_hi),
        .running (running),
        .fin     (fin),
        .pre_ovf (pre_ovf),
        .prod    (prod),
        .quo     (quo),
        .rem     (rem)
    );

    muldiv_fix #(.W(W)) u_fix (
        .ctl     (ctl_q),
        .prod    (prod),
        .quo     (quo),
        .rem     (rem),
        .pre_ovf (pre_ovf),
        .lat_lo  (lat_lo),
        .lat_hi  (lat_hi),
        .new_lo  (new_lo),
        .new_hi  (new_hi),
        .err     (err),
        .ovf     (ovf)
    );

    // Register results and flags when the engine finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            div_err  <= 1'b0;
            wide_ovf <= 1'b0;
            res_lo   <= '0;
            res_hi   <= '0;
        end else begin
            done    <= fin;
            div_err <= fin & err;
            if (fin) begin
                wide_ovf <= ovf;
                res_lo   <= new_lo;
                res_hi   <= new_hi;
            end
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res_lo) && $stable(res_hi) && $stable(wide_ovf)));

    // R2
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ($stable(lat_lo) && $stable(lat_hi)));

    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> done);

    // R11
    err_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> (res_lo == lat_lo && res_hi == lat_hi));

    // R12
    negate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctl_q.negate));

endmodule

// File: tb/sim_muldiv_unit.sv
// Bench: behavioural reference model compared on every clock.
module sim_muldiv_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op_i = 2'b00;
    logic         bw_i = 1'b0;
    logic [1:0]   rep_i = 2'b00;
    logic [W-1:0] lo_i = '0, hi_i = '0, src_i = '0;
    logic         busy, done, div_err, wide_ovf;
    logic [W-1:0] res_lo, res_hi;

    muldiv_unit #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .byte_mode(bw_i),
        .rep_mode(rep_i), .acc_lo(lo_i), .acc_hi(hi_i), .src(src_i),
        .busy(busy), .done(done), .div_err(div_err), .wide_ovf(wide_ovf),
        .res_lo(res_lo), .res_hi(res_hi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    tests = 0;
    int    fails = 0;
    int    cyc = 0;
    string cur_tag = "R2";
    bit    checking = 1'b0;

    // Reference model state
    int          m_cnt = 0;
    logic        m_done = 0, m_err = 0, m_ovf = 0;
    logic [15:0] m_lo = 0, m_hi = 0;
    logic [15:0] p_lo, p_hi;
    logic        p_err, p_ovf;

    // Behavioural arithmetic from the requirements.
    function automatic void model_calc(input logic [1:0] op, input logic bw,
            input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] s,
            input logic [1:0] rep, output logic [15:0] nlo, output logic [15:0] nhi,
            output logic err, output logic ov);
        longint n = bw ? 8 : 16;
        longint one = 1;
        longint a, b, p, dv, d, q, r;
        bit ng = (rep != 2'b00);
        nlo = lo; nhi = hi; err = 0; ov = 0;
        if (op[1] == 1'b0) begin
            if (op[0] == 1'b0) begin
                a = bw ? longint'(lo[7:0]) : longint'(lo);
                b = bw ? longint'(s[7:0])  : longint'(s);
                p = a * b;
                ov = ((p >>> n) != 0);
            end else begin
                a = bw ? longint'($signed(lo[7:0])) : longint'($signed(lo));
                b = bw ? longint'($signed(s[7:0]))  : longint'($signed(s));
                p = a * b;
                ov = (p < -(one << (n-1))) || (p >= (one << (n-1)));
            end
            if (ng) p = -p;
            nlo = p[15:0];
            if (!bw) nhi = p[31:16];
        end else begin
            if (op[0] == 1'b0) begin
                dv = bw ? longint'(lo) : longint'({hi, lo});
                d  = bw ? longint'(s[7:0]) : longint'(s);
                if (d == 0) err = 1;
                else begin
                    q = dv / d; r = dv % d;
                    if (q >= (one << n)) err = 1;
                end
            end else begin
                dv = bw ? longint'($signed(lo)) : longint'($signed({hi, lo}));
                d  = bw ? longint'($signed(s[7:0])) : longint'($signed(s));
                if (d == 0) err = 1;
                else begin
                    q = dv / d; r = dv % d;
                    if (q < -(one << (n-1)) || q >= (one << (n-1))) err = 1;
                    if (ng) q = -q;
                end
            end
            if (!err) begin
                if (bw) nlo = {r[7:0], q[7:0]};
                else begin nlo = q[15:0]; nhi = r[15:0]; end
            end
        end
    endfunction

    // Model timing: accept when idle, complete n+1 edges later.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; m_err = 0; m_ovf = 0; m_lo = 0; m_hi = 0;
        end else begin
            m_done = 0; m_err = 0;
            if (m_cnt == 0 && start) begin
                model_calc(op_i, bw_i, lo_i, hi_i, src_i, rep_i, p_lo, p_hi, p_err, p_ovf);
                m_cnt = (bw_i ? 8 : 16) + 1;
            end else if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_done = 1; m_err = p_err; m_ovf = p_ovf; m_lo = p_lo; m_hi = p_hi;
                end
            end
        end
    end

    // Compare all outputs against the model on every cycle.
    always @(negedge clk) begin
        if (rst_n && checking) begin
            tests++;
            if (busy !== (m_cnt > 0) || done !== m_done || div_err !== m_err ||
                wide_ovf !== m_ovf || res_lo !== m_lo || res_hi !== m_hi) begin
                fails++;
                $display("FAIL %s: got busy=%b done=%b err=%b ovf=%b lo=%h hi=%h, expected busy=%b done=%b err=%b ovf=%b lo=%h hi=%h",
                         m_done ? cur_tag : "R2", busy, done, div_err, wide_ovf, res_lo, res_hi,
                         (m_cnt > 0), m_done, m_err, m_ovf, m_lo, m_hi);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            fails++;
            $display("FAIL R2 watchdog: cycles=%0d expected below 50000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic run_op(input logic [1:0] op, input logic bw, input logic [15:0] lo,
                          input logic [15:0] hi, input logic [15:0] s,
                          input logic [1:0] rep, input string tag);
        @(negedge clk); #1;
        op_i = op; bw_i = bw; lo_i = lo; hi_i = hi; src_i = s; rep_i = rep;
        cur_tag = tag; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        repeat (bw ? 10 : 18) @(negedge clk);
    endtask

    // R12 and R2: disturb the prefix and pulse a stray start mid-operation.
    task automatic run_disturbed(input logic [1:0] op, input logic [15:0] lo,
                                 input logic [15:0] hi, input logic [15:0] s,
                                 input logic [1:0] rep, input string tag);
        @(negedge clk); #1;
        op_i = op; bw_i = 1'b0; lo_i = lo; hi_i = hi; src_i = s; rep_i = rep;
        cur_tag = tag; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        rep_i = (rep == 2'b00) ? 2'b11 : 2'b00;
        op_i = 2'b00; lo_i = 16'h1234; hi_i = 16'h5678; src_i = 16'h0003; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        repeat (16) @(negedge clk);
        #1 rep_i = 2'b00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        tests++;
        if (busy !== 0 || done !== 0 || div_err !== 0 || wide_ovf !== 0 ||
            res_lo !== 0 || res_hi !== 0) begin
            fails++;
            $display("FAIL R1: got busy=%b done=%b err=%b ovf=%b lo=%h hi=%h, expected all zero",
                     busy, done, div_err, wide_ovf, res_lo, res_hi);
        end
        #1 rst_n = 1'b1;
        checking = 1'b1;

        // R3: unsigned multiply
        run_op(2'b00, 1'b0, 16'd3,    16'h0000, 16'd2,    2'b00, "R3");
        run_op(2'b00, 1'b1, 16'h00FF, 16'hBEEF, 16'h00FF, 2'b00, "R3");
        run_op(2'b00, 1'b0, 16'hFFFF, 16'h0000, 16'hFFFF, 2'b00, "R3");
        // R4: signed multiply
        run_op(2'b01, 1'b0, 16'hFFFD, 16'h0000, 16'd5,    2'b00, "R4");
        run_op(2'b01, 1'b1, 16'h1105, 16'hAAAA, 16'h33FE, 2'b00, "R4");
        // R5: wide flag
        run_op(2'b01, 1'b1, 16'h0080, 16'h0000, 16'h0080, 2'b00, "R5");
        run_op(2'b00, 1'b1, 16'h0010, 16'h0000, 16'h0010, 2'b00, "R5");
        run_op(2'b01, 1'b0, 16'hFF00, 16'h0000, 16'h0080, 2'b00, "R5");
        // R6: prefix negates products
        run_op(2'b00, 1'b0, 16'd3,    16'h0000, 16'd2,    2'b01, "R6");
        run_op(2'b01, 1'b1, 16'h00FD, 16'h7777, 16'h0004, 2'b01, "R6");
        // R7: both prefix kinds alike
        run_op(2'b00, 1'b0, 16'd3,    16'h0000, 16'd2,    2'b10, "R7");
        run_op(2'b01, 1'b0, 16'h1234, 16'h0000, 16'hFFF0, 2'b10, "R7");
        // R8: unsigned divide
        run_op(2'b10, 1'b0, 16'h86A0, 16'h0001, 16'd7,    2'b00, "R8");
        run_op(2'b10, 1'b1, 16'd200,  16'hC0DE, 16'd7,    2'b00, "R8");
        // R9: signed divide signs
        run_op(2'b11, 1'b1, 16'hFFF9, 16'h0000, 16'h0002, 2'b00, "R9");
        run_op(2'b11, 1'b0, 16'd7,    16'h0000, 16'hFFFE, 2'b00, "R9");
        run_op(2'b11, 1'b0, 16'hFFF9, 16'hFFFF, 16'hFFFE, 2'b00, "R9");
        // R10: prefix on divides
        run_op(2'b11, 1'b0, 16'd100,  16'h0000, 16'd7,    2'b01, "R10");
        run_op(2'b11, 1'b1, 16'hFF00, 16'h0000, 16'h0002, 2'b10, "R10");
        run_op(2'b10, 1'b0, 16'd100,  16'h0000, 16'd7,    2'b01, "R10");
        // R11: divide errors and signed boundary
        run_op(2'b10, 1'b0, 16'h1111, 16'h2222, 16'h0000, 2'b00, "R11");
        run_op(2'b11, 1'b1, 16'h0055, 16'h3333, 16'hFF00, 2'b00, "R11");
        run_op(2'b10, 1'b1, 16'h1000, 16'h4444, 16'h0010, 2'b00, "R11");
        run_op(2'b11, 1'b1, 16'h0100, 16'h0000, 16'h0002, 2'b00, "R11");
        run_op(2'b11, 1'b1, 16'hFF00, 16'h0000, 16'h0002, 2'b00, "R11");
        run_op(2'b10, 1'b0, 16'h0000, 16'h0007, 16'h0007, 2'b00, "R11");
        // R12: prefix held through the run; stray start ignored (R2)
        run_disturbed(2'b00, 16'd3,   16'h0000, 16'd2,    2'b01, "R12");
        run_disturbed(2'b11, 16'd100, 16'h0000, 16'd7,    2'b00, "R12");
        // R2: back-to-back operations
        run_op(2'b00, 1'b0, 16'h0101, 16'h0000, 16'h0101, 2'b00, "R2");
        run_op(2'b10, 1'b1, 16'h00FF, 16'h0000, 16'h0010, 2'b00, "R2");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule